// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block gathers interrupt events from a multi-queue transmit engine and from a few local sources, and presents them to a host through a small register file. Per-queue events and bus/beacon events are latched in five secondary status registers. A primary status register summarises them: each summary bit is a live OR of one secondary field. Three further primary bits are latched directly and are not backed by any secondary register.

The host reads and writes registers through a single-cycle port. Reads are combinational and writes take effect at the clock edge. Every status register is write-one-to-clear. Writing a 1 to a summary bit in the primary register empties every secondary bit that feeds that summary. A primary mask, a mask over secondary register 2 and a global enable decide whether the single interrupt line is driven. A read-only pending register mirrors that line.

Top module: `irq_aggregator`

## Requirements
- R1: An event pulse sets its secondary bit on the next clock edge. The fields are: register 2 (word 2) holds transmit-done in bits [NQ-1:0] and descriptor-done in [16+NQ-1:16]; word 3 holds transmit-error in [NQ-1:0] and end-of-list in [16+NQ-1:16]; word 4 holds underrun in [NQ-1:0], bus errors in bits 16..18 (master abort, system error, parity) and beacon events in bits 19..23 (TIM, DTIM, DTIM sync, beacon timeout, CAB timeout); word 5 holds CBR overrun in [NQ-1:0] and CBR underrun in [16+NQ-1:16]; word 6 holds queue trigger in [NQ-1:0].
- R2: Primary status (word 0) bits 0..9 are live ORs of, in order: transmit-done, descriptor-done, transmit-error, end-of-list, underrun, the three bus errors, the five beacon bits, CBR overrun, CBR underrun and queue trigger.
- R3: Writing a secondary register clears only the bits written as 1; all other bits keep their value.
- R4: An event arriving in the same cycle as a clear of its bit wins, so the bit stays set.
- R5: Writing 1 to a primary summary bit clears every secondary bit feeding it and leaves all other secondary bits unchanged.
- R6: Primary-only bits 10, 11 and 12 (receive done, receive error, beacon not ready) are set by the local event inputs 0, 1 and 2. Each is cleared by writing 1 to it in word 0, and this leaves the secondary registers untouched.
- R7: The primary mask (word 1) gates each primary bit bitwise before it reaches the line. Reading status returns the unmasked value.
- R8: The secondary-2 mask (word 7) gates the bits of word 4 bitwise before they form the summaries that drive the line. Reading word 4 returns the unmasked value.
- R9: The global enable (word 8, bit 0) gates the line. Clearing it drops the line and keeps all status.
- R10: The pending register (word 9) reads 1 in bit 0 exactly when the interrupt line is high.
- R11: After reset all status registers, both masks and the global enable read 0, and the line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | 4 | Register word index |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data (combinational) |
| ev_txok | input | NQ | Per-queue transmit-done pulses |
| ev_txdesc | input | NQ | Per-queue descriptor-done pulses |
| ev_txerr | input | NQ | Per-queue transmit-error pulses |
| ev_eol | input | NQ | Per-queue end-of-list pulses |
| ev_urn | input | NQ | Per-queue underrun pulses |
| ev_bus_err | input | 3 | Master abort, system error, parity error |
| ev_bcn | input | 5 | TIM, DTIM, DTIM sync, beacon timeout, CAB timeout |
| ev_cbr_orn | input | NQ | Per-queue CBR overrun pulses |
| ev_cbr_urn | input | NQ | Per-queue CBR underrun pulses |
| ev_qtrig | input | NQ | Per-queue trigger pulses |
| ev_local | input | 3 | Receive done, receive error, beacon not ready |
| irq_o | output | 1 | Interrupt line |

## Verification
Assertions check several properties on every cycle. An event that coincides with a clear leaves its bit set. A clear with no event empties its bits. A quiet cycle leaves every status register unchanged. A summary clear empties the whole transmit-done field. Turning off the global enable drops the line. The pending read tracks the line. The bench's scenarios cover the rest. They confirm the exact field positions and the summary bit order, and that a summary clear leaves neighbouring fields alone. They also show that the masks and the enable hide status from the line without changing what the host reads back.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;

  localparam int REG_W   = 32;
  localparam int HI_OFS  = 16;
  localparam int NSEC    = 5;
  localparam int PRI_W   = 13;

  typedef enum logic [3:0] {
    A_PSTAT  = 4'd0,
    A_PMASK  = 4'd1,
    A_SEC0   = 4'd2,
    A_SEC1   = 4'd3,
    A_SEC2   = 4'd4,
    A_SEC3   = 4'd5,
    A_SEC4   = 4'd6,
    A_SMASK2 = 4'd7,
    A_GEN    = 4'd8,
    A_PEND   = 4'd9
  } addr_e;

  // primary bit positions
  localparam int P_TXOK   = 0;
  localparam int P_TXDESC = 1;
  localparam int P_TXERR  = 2;
  localparam int P_EOL    = 3;
  localparam int P_URN    = 4;
  localparam int P_HERR   = 5;
  localparam int P_BCN    = 6;
  localparam int P_CBRO   = 7;
  localparam int P_CBRU   = 8;
  localparam int P_QTRIG  = 9;
  localparam int P_LOCAL  = 10;

  // secondary register 2 miscellaneous fields
  localparam int S2_HERR_LSB = 16;
  localparam int S2_BCN_LSB  = 19;
  localparam logic [REG_W-1:0] S2_HERR_F = 32'h0007_0000;
  localparam logic [REG_W-1:0] S2_BCN_F  = 32'h00F8_0000;

  function automatic logic [REG_W-1:0] lo_field(int nq);
    return REG_W'((64'd1 << nq) - 64'd1);
  endfunction

  function automatic logic [REG_W-1:0] hi_field(int nq);
    return lo_field(nq) << HI_OFS;
  endfunction

endpackage

// File: rtl/irqagg_w1c.sv
module irqagg_w1c #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic [W-1:0] clr,
  output logic [W-1:0] stat
);

  logic [W-1:0] stat_nxt;
  logic         upd;

  always_comb begin
    upd      = (|evt) | (|clr);
    stat_nxt = (stat & ~clr) | evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   stat <= '0;
    else if (upd) stat <= stat_nxt;
  end

  AST_EVT_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & clr) != '0) |=> ((stat & $past(evt & clr)) == $past(evt & clr))); // R4
  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~evt) != '0) |=> ((stat & $past(clr & ~evt)) == '0)); // R3
  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt == '0 && clr == '0) |=> $stable(stat)); // R3

endmodule

// File: rtl/irqagg_summary.sv
module irqagg_summary
  import irqagg_pkg::*;
#(
  parameter int NQ = 10
) (
  input  logic [REG_W-1:0] s0,
  input  logic [REG_W-1:0] s1,
  input  logic [REG_W-1:0] s2,
  input  logic [REG_W-1:0] s3,
  input  logic [REG_W-1:0] s4,
  input  logic [2:0]       local_bits,
  output logic [PRI_W-1:0] sum
);

  localparam logic [REG_W-1:0] LO = lo_field(NQ);
  localparam logic [REG_W-1:0] HI = hi_field(NQ);

  always_comb begin
    sum                       = '0;
    sum[P_TXOK]               = |(s0 & LO);
    sum[P_TXDESC]             = |(s0 & HI);
    sum[P_TXERR]              = |(s1 & LO);
    sum[P_EOL]                = |(s1 & HI);
    sum[P_URN]                = |(s2 & LO);
    sum[P_HERR]               = |(s2 & S2_HERR_F);
    sum[P_BCN]                = |(s2 & S2_BCN_F);
    sum[P_CBRO]               = |(s3 & LO);
    sum[P_CBRU]               = |(s3 & HI);
    sum[P_QTRIG]              = |(s4 & LO);
    sum[P_LOCAL +: 3]         = local_bits;
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irqagg_pkg::*;
#(
  parameter int NQ = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_we,
  input  logic [3:0]       host_addr,
  input  logic [31:0]      host_wdata,
  output logic [31:0]      host_rdata,
  input  logic [NQ-1:0]    ev_txok,
  input  logic [NQ-1:0]    ev_txdesc,
  input  logic [NQ-1:0]    ev_txerr,
  input  logic [NQ-1:0]    ev_eol,
  input  logic [NQ-1:0]    ev_urn,
  input  logic [2:0]       ev_bus_err,
  input  logic [4:0]       ev_bcn,
  input  logic [NQ-1:0]    ev_cbr_orn,
  input  logic [NQ-1:0]    ev_cbr_urn,
  input  logic [NQ-1:0]    ev_qtrig,
  input  logic [2:0]       ev_local,
  output logic             irq_o
);

  localparam logic [REG_W-1:0] LO = lo_field(NQ);
  localparam logic [REG_W-1:0] HI = hi_field(NQ);

  logic [REG_W-1:0] sec_evt  [NSEC];
  logic [REG_W-1:0] sec_clr  [NSEC];
  logic [REG_W-1:0] sec_stat [NSEC];
  logic [2:0]       loc_clr;
  logic [2:0]       loc_stat;
  logic [PRI_W-1:0] sum_raw;
  logic [PRI_W-1:0] sum_line;
  logic [PRI_W-1:0] pmask, pmask_nxt;
  logic [REG_W-1:0] smask2, smask2_nxt;
  logic             gen_en, gen_en_nxt;
  logic             pri_wr;
  logic [REG_W-1:0] s2_gated;

  // event placement
  always_comb begin
    sec_evt[0] = (REG_W'(ev_txok)    & LO) | ((REG_W'(ev_txdesc)  << HI_OFS) & HI);
    sec_evt[1] = (REG_W'(ev_txerr)   & LO) | ((REG_W'(ev_eol)     << HI_OFS) & HI);
    sec_evt[2] = (REG_W'(ev_urn)     & LO) | (REG_W'(ev_bus_err)  << S2_HERR_LSB)
                                          | (REG_W'(ev_bcn)      << S2_BCN_LSB);
    sec_evt[3] = (REG_W'(ev_cbr_orn) & LO) | ((REG_W'(ev_cbr_urn) << HI_OFS) & HI);
    sec_evt[4] = (REG_W'(ev_qtrig)   & LO);
  end

  // clear vectors: direct writes plus summary fan-out
  always_comb begin
    pri_wr = host_we && (host_addr == A_PSTAT);
    for (int k = 0; k < NSEC; k++)
      sec_clr[k] = (host_we && (host_addr == 4'(A_SEC0) + 4'(k))) ? host_wdata : '0;
    if (pri_wr) begin
      if (host_wdata[P_TXOK])   sec_clr[0] = sec_clr[0] | LO;
      if (host_wdata[P_TXDESC]) sec_clr[0] = sec_clr[0] | HI;
      if (host_wdata[P_TXERR])  sec_clr[1] = sec_clr[1] | LO;
      if (host_wdata[P_EOL])    sec_clr[1] = sec_clr[1] | HI;
      if (host_wdata[P_URN])    sec_clr[2] = sec_clr[2] | LO;
      if (host_wdata[P_HERR])   sec_clr[2] = sec_clr[2] | S2_HERR_F;
      if (host_wdata[P_BCN])    sec_clr[2] = sec_clr[2] | S2_BCN_F;
      if (host_wdata[P_CBRO])   sec_clr[3] = sec_clr[3] | LO;
      if (host_wdata[P_CBRU])   sec_clr[3] = sec_clr[3] | HI;
      if (host_wdata[P_QTRIG])  sec_clr[4] = sec_clr[4] | LO;
    end
    loc_clr = pri_wr ? host_wdata[P_LOCAL +: 3] : 3'b000;
  end

  for (genvar g = 0; g < NSEC; g++) begin : g_sec
    irqagg_w1c #(.W(REG_W)) i_sec (
      .clk  (clk),
      .rst_n(rst_n),
      .evt  (sec_evt[g]),
      .clr  (sec_clr[g]),
      .stat (sec_stat[g])
    );
  end

  irqagg_w1c #(.W(3)) i_local (
    .clk  (clk),
    .rst_n(rst_n),
    .evt  (ev_local),
    .clr  (loc_clr),
    .stat (loc_stat)
  );

  assign s2_gated = sec_stat[2] & smask2;

  irqagg_summary #(.NQ(NQ)) i_sum_raw (
    .s0(sec_stat[0]), .s1(sec_stat[1]), .s2(sec_stat[2]),
    .s3(sec_stat[3]), .s4(sec_stat[4]), .local_bits(loc_stat), .sum(sum_raw)
  );

  irqagg_summary #(.NQ(NQ)) i_sum_line (
    .s0(sec_stat[0]), .s1(sec_stat[1]), .s2(s2_gated),
    .s3(sec_stat[3]), .s4(sec_stat[4]), .local_bits(loc_stat), .sum(sum_line)
  );

  // control registers: next state
  always_comb begin
    pmask_nxt  = pmask;
    smask2_nxt = smask2;
    gen_en_nxt = gen_en;
    if (host_we) begin
      case (host_addr)
        A_PMASK:  pmask_nxt  = host_wdata[PRI_W-1:0];
        A_SMASK2: smask2_nxt = host_wdata;
        A_GEN:    gen_en_nxt = host_wdata[0];
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pmask  <= '0;
      smask2 <= '0;
      gen_en <= 1'b0;
    end else if (host_we) begin
      pmask  <= pmask_nxt;
      smask2 <= smask2_nxt;
      gen_en <= gen_en_nxt;
    end
  end

  assign irq_o = gen_en & (|(sum_line & pmask));

  always_comb begin
    case (host_addr)
      A_PSTAT:  host_rdata = REG_W'(sum_raw);
      A_PMASK:  host_rdata = REG_W'(pmask);
      A_SEC0:   host_rdata = sec_stat[0];
      A_SEC1:   host_rdata = sec_stat[1];
      A_SEC2:   host_rdata = sec_stat[2];
      A_SEC3:   host_rdata = sec_stat[3];
      A_SEC4:   host_rdata = sec_stat[4];
      A_SMASK2: host_rdata = smask2;
      A_GEN:    host_rdata = REG_W'(gen_en);
      A_PEND:   host_rdata = REG_W'(irq_o);
      default:  host_rdata = '0;
    endcase
  end

  AST_SUMMARY_CLR_TXOK: assert property (@(posedge clk) disable iff (!rst_n)
    (pri_wr && host_wdata[P_TXOK] && ev_txok == '0) |=> ((sec_stat[0] & LO) == '0)); // R5
  AST_ENABLE_OFF_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_we && host_addr == A_GEN && !host_wdata[0]) |=> !irq_o); // R9
  AST_LINE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (sum_raw != '0)); // R7
  AST_PEND_MIRRORS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr == A_PEND) |-> (host_rdata[0] == irq_o)); // R10

endmodule

// File: tb/test_irq_aggregator.sv
module test_irq_aggregator;

  localparam int NQ = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_we = 1'b0;
  logic [3:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic [NQ-1:0] ev_txok = '0, ev_txdesc = '0, ev_txerr = '0, ev_eol = '0, ev_urn = '0;
  logic [NQ-1:0] ev_cbr_orn = '0, ev_cbr_urn = '0, ev_qtrig = '0;
  logic [2:0] ev_bus_err = '0, ev_local = '0;
  logic [4:0] ev_bcn = '0;
  logic irq_o;

  always #4 clk = ~clk;

  irq_aggregator #(.NQ(NQ)) i_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .ev_txok(ev_txok), .ev_txdesc(ev_txdesc), .ev_txerr(ev_txerr), .ev_eol(ev_eol),
    .ev_urn(ev_urn), .ev_bus_err(ev_bus_err), .ev_bcn(ev_bcn),
    .ev_cbr_orn(ev_cbr_orn), .ev_cbr_urn(ev_cbr_urn), .ev_qtrig(ev_qtrig),
    .ev_local(ev_local), .irq_o(irq_o)
  );

  typedef struct {
    bit          is_irq;
    logic [3:0]  addr;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // monitor: pops expected items and compares
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = it.is_irq ? {31'b0, irq_o} : host_rdata;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: addr=%0d actual=0x%08h expected=0x%08h", it.tag, it.addr, act, it.exp);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step();
    @(negedge clk);
    host_we = 1'b0;
    ev_txok = '0; ev_txdesc = '0; ev_txerr = '0; ev_eol = '0; ev_urn = '0;
    ev_cbr_orn = '0; ev_cbr_urn = '0; ev_qtrig = '0;
    ev_bus_err = '0; ev_local = '0; ev_bcn = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    step();
  endtask

  task automatic chk(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    host_addr = a;
    it.is_irq = 1'b0; it.addr = a; it.exp = e; it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  task automatic chk_irq(input logic e, input string tag);
    item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.addr = 4'd0; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
    #2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state
    chk(4'd0, 32'h0, "R11 primary");
    chk(4'd2, 32'h0, "R11 sec0");
    chk(4'd4, 32'h0, "R11 sec2");
    chk(4'd1, 32'h0, "R11 pmask");
    chk(4'd8, 32'h0, "R11 enable");
    chk_irq(1'b0, "R11 line");

    // R1 / R2 capture and summaries
    ev_txok = 10'h005; ev_txdesc = 10'h200; step();
    chk(4'd2, 32'h0200_0005, "R1 sec0 fields");
    chk(4'd0, 32'h0000_0003, "R2 txok/txdesc summary");
    ev_txerr = 10'h001; ev_eol = 10'h100;
    ev_urn = 10'h3FF; ev_bus_err = 3'b010; ev_bcn = 5'b01000; step();
    chk(4'd3, 32'h0100_0001, "R1 sec1 fields");
    chk(4'd4, 32'h0042_03FF, "R1 sec2 fields");
    chk(4'd0, 32'h0000_007F, "R2 summary up to beacon");
    ev_cbr_orn = 10'h002; ev_cbr_urn = 10'h010; ev_qtrig = 10'h080;
    ev_local = 3'b101; step();
    chk(4'd5, 32'h0010_0002, "R1 sec3 fields");
    chk(4'd6, 32'h0000_0080, "R1 sec4 field");
    chk(4'd0, 32'h0000_17FF, "R6 local bits set");

    // R3 partial W1C
    wr(4'd2, 32'h0000_0001);
    chk(4'd2, 32'h0200_0004, "R3 sec0 partial clear");
    chk(4'd0, 32'h0000_17FF, "R3 summary kept");

    // R4 event beats simultaneous clear
    host_we = 1'b1; host_addr = 4'd2; host_wdata = 32'h0000_0004; ev_txok = 10'h004;
    step();
    chk(4'd2, 32'h0200_0004, "R4 event wins");

    // R5 summary clear fans out
    wr(4'd0, 32'h0000_0001);
    chk(4'd2, 32'h0200_0000, "R5 txok field emptied");
    chk(4'd0, 32'h0000_17FE, "R5 primary after clear");
    chk(4'd3, 32'h0100_0001, "R5 sec1 untouched");
    wr(4'd0, 32'h0000_0020);
    chk(4'd4, 32'h0040_03FF, "R5 bus errors emptied only");

    // R6 primary-only clear
    wr(4'd0, 32'h0000_0400);
    chk(4'd0, 32'h0000_13DE, "R6 local bit cleared");
    chk(4'd5, 32'h0010_0002, "R6 secondary untouched");

    // R7 primary mask, R10 pending
    wr(4'd8, 32'h1);
    chk_irq(1'b0, "R7 all masked");
    wr(4'd1, 32'h0000_1000);
    chk_irq(1'b1, "R7 beacon-not-ready unmasked");
    chk(4'd0, 32'h0000_13DE, "R7 read unmasked");
    chk(4'd9, 32'h1, "R10 pending high");

    // R9 global enable
    wr(4'd8, 32'h0);
    chk_irq(1'b0, "R9 disabled");
    chk(4'd9, 32'h0, "R10 pending low");
    chk(4'd0, 32'h0000_13DE, "R9 status kept");
    wr(4'd8, 32'h1);
    chk_irq(1'b1, "R9 re-enabled");

    // R8 secondary-2 mask
    wr(4'd1, 32'h0000_0040);
    chk_irq(1'b0, "R8 beacon bits masked");
    wr(4'd7, 32'h0040_0000);
    chk_irq(1'b1, "R8 beacon timeout unmasked");
    wr(4'd7, 32'h0008_0000);
    chk_irq(1'b0, "R8 other beacon bit only");
    chk(4'd4, 32'h0040_03FF, "R8 sec2 read unmasked");

    // R5 beacon summary clear, R8 underrun path
    wr(4'd0, 32'h0000_0040);
    chk(4'd4, 32'h0000_03FF, "R5 beacon field emptied");
    wr(4'd7, 32'hFFFF_FFFF);
    chk_irq(1'b0, "R8 no beacon left");
    wr(4'd1, 32'h0000_0010);
    chk_irq(1'b1, "R8 underrun unmasked");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule